// File: doc/BRIEF.md
# Programmable-Modulus Counter-Mode Keystream Unit

This block holds the counter state of a block-cipher counter mode and combines keystream with data. A 128-bit counter is presented to an external block-encrypt function. The returned keystream block is XORed with the input data block to give the output. Because the operation is a plain XOR, one path serves both encryption and decryption.

After each block the counter advances by one, but the carry is confined to a programmable low field of M bits. M ranges from 8 to 128 in steps of 8, and the bits from position M upward never change. Software loads and reads the counter and M through an indexed bank of eight 64-bit context registers. The layout of that bank depends on a layout select input. The compact layout uses registers 1 to 3. The plain layout uses registers 5 to 7 and requires registers 1 to 4 to hold zero.

Only one block is in flight at a time. The counter shown to the cipher is the value from before the increment. The counter advances when the keystream is accepted, so a context read after a message returns the next counter value and a later message can resume the sequence.

Top module: `ctr_keystream_unit`

## Requirements
- R1: After reset the counter is zero, M is 128, in_ready is 1, and enc_req, out_valid and ctx_err are 0.
- R2: When enc_ack is high while enc_req is high, out_valid is 1 for exactly one cycle on the next cycle, with out_data equal to enc_ks XOR the accepted in_data. Feeding a ciphertext back through the same counter value returns the plaintext.
- R3: An input block is accepted when in_valid and in_ready are both high. On the next cycle enc_req is high, in_ready is low, and enc_ctr carries the counter value from before the increment. enc_ctr stays stable until enc_ack.
- R4: On keystream acceptance the counter becomes (counter + 1) mod 2^M in its low M bits, and bits M and above stay unchanged. With M = 128 the whole counter wraps from all ones to zero.
- R5: M is written as bits [7:0] of the modulus register, and the other bits are ignored. A value that is not a multiple of 8, or lies outside 8..128, raises ctx_err for one cycle and leaves the previous M in place.
- R6: With layout_sel = 1 (compact layout), register 1 holds counter bits [63:0], register 2 holds bits [127:64], and register 3 holds M. Registers 0 and 4 to 7 read as zero, and writes to them change nothing and raise no error.
- R7: With layout_sel = 0 (plain layout), register 5 holds counter bits [63:0], register 6 holds bits [127:64], and register 7 holds M. Registers 1 to 4 read as zero. A nonzero write to one of them raises ctx_err, and a zero write does not.
- R8: A context read of the counter after a block returns the incremented value, which is the counter the next block will use.
- R9: A context write while a block is in flight (enc_req high) is ignored and raises ctx_err on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout_sel | input | 1 | Context layout: 0 plain, 1 compact |
| ctx_we | input | 1 | Context register write strobe |
| ctx_addr | input | 3 | Context register index 0..7 |
| ctx_wdata | input | 64 | Context write data |
| ctx_rdata | output | 64 | Context read data for ctx_addr (combinational) |
| ctx_err | output | 1 | One-cycle pulse for a rejected context write |
| in_valid | input | 1 | Input block present |
| in_data | input | 128 | Input data block (plaintext or ciphertext) |
| in_ready | output | 1 | Unit idle and able to accept a block |
| enc_req | output | 1 | Keystream request to the block cipher |
| enc_ctr | output | 128 | Counter value to be encrypted |
| enc_ack | input | 1 | Keystream is valid on enc_ks |
| enc_ks | input | 128 | Encrypted counter from the block cipher |
| out_valid | output | 1 | out_data is valid (one-cycle pulse) |
| out_data | output | 128 | Keystream XOR input block |

## Verification
The bench builds the unit with its defaults: a 128-bit counter, 64-bit context words, 8-bit lanes and eight context registers. This puts both ends of the modulus range, M = 8 and M = 128, within reach, together with a mid-field value of 32. A counter with all ones in its low field therefore exercises both a carry confined to the lowest byte and a full-width wrap to zero. Eight registers are enough for the compact and plain layouts to occupy disjoint windows, so each layout's reads of the other window and of the must-be-zero registers can be checked.

// File: rtl/ctr_unit_pkg.sv
package ctr_unit_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctr_state_e;

    typedef enum logic {
        LAYOUT_PLAIN   = 1'b0,
        LAYOUT_COMPACT = 1'b1
    } ctx_layout_e;

endpackage

// File: rtl/ctr_mod_incr.sv
module ctr_mod_incr #(
    parameter int CTR_W  = 128,
    parameter int LANE_W = 8,
    parameter int MW     = 8,
    localparam int LANES = CTR_W / LANE_W
) (
    input  logic [CTR_W-1:0] ctr,
    input  logic [MW-1:0]    m_bits,
    output logic [CTR_W-1:0] ctr_next
);
    logic [CTR_W-1:0] lane_mask;
    logic [CTR_W-1:0] plus_one;

    // A lane takes part in the carry when it lies fully below bit M.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*LANE_W +: LANE_W] =
            (MW'((g + 1) * LANE_W) <= m_bits) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
    end

    assign plus_one = ctr + CTR_W'(1);
    assign ctr_next = (plus_one & lane_mask) | (ctr & ~lane_mask);
endmodule

// File: rtl/ctr_m_check.sv
module ctr_m_check #(
    parameter int CTR_W  = 128,
    parameter int LANE_W = 8,
    parameter int MW     = 8,
    localparam int LB    = $clog2(LANE_W)
) (
    input  logic [MW-1:0] m_field,
    output logic          m_ok
);
    always_comb begin
        m_ok = (m_field != '0)
            && (m_field[LB-1:0] == '0)
            && (int'(m_field) <= CTR_W);
    end
endmodule

// File: rtl/ctr_ctx_map.sv
module ctr_ctx_map
    import ctr_unit_pkg::*;
#(
    parameter int CTR_W   = 128,
    parameter int CTX_W   = 64,
    parameter int NUM_CTX = 8,
    parameter int MW      = 8,
    localparam int AW        = $clog2(NUM_CTX),
    localparam int CTR_WORDS = CTR_W / CTX_W,
    localparam int IW        = (CTR_WORDS > 1) ? $clog2(CTR_WORDS) : 1
) (
    input  ctx_layout_e      layout,
    input  logic [AW-1:0]    addr,
    input  logic [CTR_W-1:0] ctr,
    input  logic [MW-1:0]    m_bits,
    output logic             word_hit,
    output logic [IW-1:0]    word_idx,
    output logic             mod_hit,
    output logic             zero_hit,
    output logic [CTX_W-1:0] rdata
);
    localparam int PLAIN_BASE   = NUM_CTX - CTR_WORDS - 1;
    localparam int COMPACT_BASE = 1;

    int base;
    int a;

    always_comb begin
        base     = (layout == LAYOUT_COMPACT) ? COMPACT_BASE : PLAIN_BASE;
        a        = int'(addr);
        word_hit = (a >= base) && (a < base + CTR_WORDS);
        word_idx = IW'(a - base);
        mod_hit  = (a == base + CTR_WORDS);
        zero_hit = (layout == LAYOUT_PLAIN) && (a >= 1) && (a < base);
        if (word_hit)
            rdata = ctr[int'(word_idx)*CTX_W +: CTX_W];
        else if (mod_hit)
            rdata = CTX_W'(m_bits);
        else
            rdata = '0;
    end
endmodule

// File: rtl/ctr_keystream_unit.sv
module ctr_keystream_unit
    import ctr_unit_pkg::*;
#(
    parameter int CTR_W   = 128,
    parameter int CTX_W   = 64,
    parameter int LANE_W  = 8,
    parameter int NUM_CTX = 8,
    localparam int AW = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             layout_sel,
    input  logic             ctx_we,
    input  logic [AW-1:0]    ctx_addr,
    input  logic [CTX_W-1:0] ctx_wdata,
    output logic [CTX_W-1:0] ctx_rdata,
    output logic             ctx_err,
    input  logic             in_valid,
    input  logic [CTR_W-1:0] in_data,
    output logic             in_ready,
    output logic             enc_req,
    output logic [CTR_W-1:0] enc_ctr,
    input  logic             enc_ack,
    input  logic [CTR_W-1:0] enc_ks,
    output logic             out_valid,
    output logic [CTR_W-1:0] out_data
);
    localparam int MW        = $clog2(CTR_W + 1);
    localparam int CTR_WORDS = CTR_W / CTX_W;
    localparam int IW        = (CTR_WORDS > 1) ? $clog2(CTR_WORDS) : 1;

    typedef struct packed {
        ctr_state_e       st;
        logic [CTR_W-1:0] ctr;
        logic [MW-1:0]    m;
        logic [CTR_W-1:0] blk;
        logic [CTR_W-1:0] out;
        logic             ov;
        logic             err;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic [CTR_W-1:0] ctr_inc;
    logic             word_hit, mod_hit, zero_hit, m_ok;
    logic [IW-1:0]    word_idx;
    ctx_layout_e      layout;

    assign layout = ctx_layout_e'(layout_sel);

    ctr_mod_incr #(.CTR_W(CTR_W), .LANE_W(LANE_W), .MW(MW)) u_incr (
        .ctr      (state_q.ctr),
        .m_bits   (state_q.m),
        .ctr_next (ctr_inc)
    );

    ctr_m_check #(.CTR_W(CTR_W), .LANE_W(LANE_W), .MW(MW)) u_mchk (
        .m_field (ctx_wdata[MW-1:0]),
        .m_ok    (m_ok)
    );

    ctr_ctx_map #(.CTR_W(CTR_W), .CTX_W(CTX_W), .NUM_CTX(NUM_CTX), .MW(MW)) u_map (
        .layout   (layout),
        .addr     (ctx_addr),
        .ctr      (state_q.ctr),
        .m_bits   (state_q.m),
        .word_hit (word_hit),
        .word_idx (word_idx),
        .mod_hit  (mod_hit),
        .zero_hit (zero_hit),
        .rdata    (ctx_rdata)
    );

    always_comb begin
        state_d     = state_q;
        state_d.ov  = 1'b0;
        state_d.err = 1'b0;

        case (state_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d.blk = in_data;
                    state_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (enc_ack) begin
                    state_d.out = enc_ks ^ state_q.blk;
                    state_d.ov  = 1'b1;
                    state_d.ctr = ctr_inc;
                    state_d.st  = ST_IDLE;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase

        if (ctx_we) begin
            if (state_q.st != ST_IDLE) begin
                state_d.err = 1'b1;
            end else if (word_hit) begin
                state_d.ctr[int'(word_idx)*CTX_W +: CTX_W] = ctx_wdata;
            end else if (mod_hit) begin
                if (m_ok) state_d.m   = ctx_wdata[MW-1:0];
                else      state_d.err = 1'b1;
            end else if (zero_hit && (ctx_wdata != '0)) begin
                state_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.st  <= ST_IDLE;
            state_q.ctr <= '0;
            state_q.m   <= MW'(CTR_W);
            state_q.blk <= '0;
            state_q.out <= '0;
            state_q.ov  <= 1'b0;
            state_q.err <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    logic [CTR_W-1:0] ctr_cur;
    logic [MW-1:0]    m_cur;
    assign ctr_cur = state_q.ctr;
    assign m_cur   = state_q.m;

    assign in_ready  = (state_q.st == ST_IDLE);
    assign enc_req   = (state_q.st == ST_WAIT);
    assign enc_ctr   = state_q.ctr;
    assign out_valid = state_q.ov;
    assign out_data  = state_q.out;
    assign ctx_err   = state_q.err;
endmodule

// File: rtl/ctr_keystream_unit_chk.sv
module ctr_keystream_unit_chk #(
    parameter int CTR_W  = 128,
    parameter int LANE_W = 8,
    parameter int MW     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctx_we,
    input logic             ctx_err,
    input logic             in_ready,
    input logic             enc_req,
    input logic [CTR_W-1:0] enc_ctr,
    input logic             enc_ack,
    input logic             out_valid,
    input logic [CTR_W-1:0] ctr_q,
    input logic [MW-1:0]    m_q
);
    // R3
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_req && !enc_ack && !ctx_we) |=> (enc_req && $stable(enc_ctr)));

    // R3
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && enc_req));

    // R2
    out_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(enc_req && enc_ack));

    // R4
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_req && enc_ack) |=> ((ctr_q >> m_q) == ($past(ctr_q) >> $past(m_q))));

    // R4
    ctr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_we && !(enc_req && enc_ack)) |=> $stable(ctr_q));

    // R5
    m_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q >= MW'(LANE_W)) && (int'(m_q) <= CTR_W) && (int'(m_q) % LANE_W == 0));

    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_we && enc_req) |=> ctx_err);
endmodule

bind ctr_keystream_unit ctr_keystream_unit_chk #(
    .CTR_W(CTR_W), .LANE_W(LANE_W), .MW(MW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx_we    (ctx_we),
    .ctx_err   (ctx_err),
    .in_ready  (in_ready),
    .enc_req   (enc_req),
    .enc_ctr   (enc_ctr),
    .enc_ack   (enc_ack),
    .out_valid (out_valid),
    .ctr_q     (ctr_cur),
    .m_q       (m_cur)
);

// File: tb/ctr_keystream_unit_bench.sv
module ctr_keystream_unit_bench;
    localparam int CW = 128;
    localparam logic [CW-1:0] KS_KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          layout_sel = 1'b0;
    logic          ctx_we = 1'b0;
    logic [2:0]    ctx_addr = '0;
    logic [63:0]   ctx_wdata = '0;
    logic [63:0]   ctx_rdata;
    logic          ctx_err;
    logic          in_valid = 1'b0;
    logic [CW-1:0] in_data = '0;
    logic          in_ready;
    logic          enc_req;
    logic [CW-1:0] enc_ctr;
    logic          enc_ack = 1'b0;
    logic [CW-1:0] enc_ks = '0;
    logic          out_valid;
    logic [CW-1:0] out_data;

    int vectors = 0;
    int miscompares = 0;

    logic [CW-1:0] model_ctr = '0;
    int            model_m = 128;

    always #10 clk = ~clk;

    ctr_keystream_unit u_ctr_keystream_unit (
        .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel),
        .ctx_we(ctx_we), .ctx_addr(ctx_addr), .ctx_wdata(ctx_wdata),
        .ctx_rdata(ctx_rdata), .ctx_err(ctx_err),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .enc_req(enc_req), .enc_ctr(enc_ctr), .enc_ack(enc_ack), .enc_ks(enc_ks),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [CW-1:0] stub_ks(input logic [CW-1:0] c);
        return {c[63:0], c[127:64]} ^ KS_KEY;
    endfunction

    function automatic logic [CW-1:0] next_ctr(input logic [CW-1:0] c, input int m);
        logic [CW-1:0] msk;
        msk = (m >= CW) ? '1 : ((CW'(1) << m) - CW'(1));
        return (c & ~msk) | ((c + CW'(1)) & msk);
    endfunction

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int base_addr();
        return layout_sel ? 1 : 5;
    endfunction

    task automatic ctx_write(input int addr, input logic [63:0] data, input bit exp_err, input string req);
        @(negedge clk);
        ctx_we = 1'b1; ctx_addr = 3'(addr); ctx_wdata = data;
        @(negedge clk);
        ctx_we = 1'b0;
        check(req, CW'(ctx_err), CW'(exp_err));
    endtask

    task automatic ctx_read(input int addr, input logic [63:0] exp, input string req);
        @(negedge clk);
        ctx_addr = 3'(addr);
        #1;
        check(req, CW'(ctx_rdata), CW'(exp));
    endtask

    task automatic load_ctr(input logic [CW-1:0] c);
        ctx_write(base_addr(), c[63:0], 1'b0, "R6/R7 ctr lo write");
        ctx_write(base_addr() + 1, c[127:64], 1'b0, "R6/R7 ctr hi write");
        model_ctr = c;
    endtask

    task automatic set_m(input int m, input bit ok);
        ctx_write(base_addr() + 2, 64'(m), !ok, "R5 modulus write err flag");
        if (ok) model_m = m;
        ctx_read(base_addr() + 2, 64'(model_m), "R5 modulus readback");
    endtask

    task automatic read_ctr(input string req);
        ctx_read(base_addr(), model_ctr[63:0], req);
        ctx_read(base_addr() + 1, model_ctr[127:64], req);
    endtask

    task automatic run_block(input logic [CW-1:0] d, input bit poke, output logic [CW-1:0] res);
        logic [CW-1:0] exp;
        exp = stub_ks(model_ctr) ^ d;
        @(negedge clk);
        check("R3 in_ready idle", CW'(in_ready), CW'(1));
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 enc_req after accept", CW'(enc_req), CW'(1));
        check("R3 in_ready low in flight", CW'(in_ready), CW'(0));
        check("R3 pre-increment counter", enc_ctr, model_ctr);
        if (poke) begin
            ctx_we = 1'b1; ctx_addr = 3'(base_addr()); ctx_wdata = 64'hDEAD_BEEF_0000_0001;
            @(negedge clk);
            ctx_we = 1'b0;
            check("R9 busy write error", CW'(ctx_err), CW'(1));
        end else begin
            @(negedge clk);
        end
        check("R3 enc_ctr held", enc_ctr, model_ctr);
        enc_ack = 1'b1; enc_ks = stub_ks(enc_ctr);
        @(negedge clk);
        enc_ack = 1'b0;
        check("R2 out_valid", CW'(out_valid), CW'(1));
        check("R2 out_data", out_data, exp);
        res = out_data;
        @(negedge clk);
        check("R2 out_valid single cycle", CW'(out_valid), CW'(0));
        model_ctr = next_ctr(model_ctr, model_m);
    endtask

    task automatic t_reset();
        check("R1 in_ready", CW'(in_ready), CW'(1));
        check("R1 enc_req", CW'(enc_req), CW'(0));
        check("R1 out_valid", CW'(out_valid), CW'(0));
        check("R1 ctx_err", CW'(ctx_err), CW'(0));
        ctx_read(5, 64'd0, "R1 counter lo");
        ctx_read(6, 64'd0, "R1 counter hi");
        ctx_read(7, 64'd128, "R1 modulus");
    endtask

    task automatic t_plain_layout();
        layout_sel = 1'b0;
        load_ctr(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        read_ctr("R7 counter readback");
        ctx_write(2, 64'h1, 1'b1, "R7 nonzero must-be-zero write");
        ctx_write(4, 64'h0, 1'b0, "R7 zero write accepted");
        ctx_write(0, 64'h55, 1'b0, "R7 reg0 ignored");
        ctx_read(2, 64'd0, "R7 must-be-zero reads zero");
        ctx_read(1, 64'd0, "R7 reg1 reads zero");
        read_ctr("R7 counter untouched");
    endtask

    task automatic t_full_width();
        logic [CW-1:0] r;
        set_m(128, 1'b1);
        run_block(128'hA5A5_0000_1111_2222_3333_4444_5555_6666, 1'b0, r);
        read_ctr("R8 next counter after block");
        load_ctr('1);
        run_block(128'h1, 1'b0, r);
        read_ctr("R4 full wrap to zero");
        check("R4 wrap value", model_ctr, '0);
    endtask

    task automatic t_narrow_wrap();
        logic [CW-1:0] r;
        set_m(8, 1'b1);
        load_ctr(128'h1111_2222_3333_4444_5555_6666_7712_34FF);
        run_block(128'h0, 1'b0, r);
        check("R4 byte wrap model", model_ctr, 128'h1111_2222_3333_4444_5555_6666_7712_3400);
        read_ctr("R4 M=8 wrap keeps upper bits");
        set_m(32, 1'b1);
        load_ctr(128'h9999_8888_7777_6666_5555_4444_FFFF_FFFF);
        run_block(128'hFFFF, 1'b0, r);
        read_ctr("R4 M=32 wrap keeps upper bits");
    endtask

    task automatic t_modulus_reject();
        set_m(12, 1'b0);
        set_m(0, 1'b0);
        set_m(136, 1'b0);
        set_m(64, 1'b1);
    endtask

    task automatic t_compact();
        logic [CW-1:0] r;
        layout_sel = 1'b1;
        ctx_read(3, 64'(model_m), "R6 modulus in reg3");
        load_ctr(128'hCAFE_0000_0000_0001_0000_0000_0000_00FE);
        read_ctr("R6 counter readback");
        ctx_write(5, 64'h1234, 1'b0, "R6 reg5 write ignored");
        ctx_write(4, 64'h1, 1'b0, "R6 reg4 write ignored");
        ctx_read(5, 64'd0, "R6 reg5 reads zero");
        ctx_read(0, 64'd0, "R6 reg0 reads zero");
        read_ctr("R6 counter unchanged by ignored writes");
        set_m(16, 1'b1);
        run_block(128'h7777, 1'b0, r);
        read_ctr("R8 compact next counter");
    endtask

    task automatic t_decrypt();
        logic [CW-1:0] start, ct, pt;
        set_m(128, 1'b1);
        start = model_ctr;
        run_block(128'h0BAD_F00D_1234_5678_9ABC_DEF0_1357_9BDF, 1'b0, ct);
        load_ctr(start);
        run_block(ct, 1'b0, pt);
        check("R2 decrypt recovers plaintext", pt, 128'h0BAD_F00D_1234_5678_9ABC_DEF0_1357_9BDF);
    endtask

    task automatic t_busy_write();
        logic [CW-1:0] r;
        layout_sel = 1'b0;
        load_ctr(128'h42);
        run_block(128'h5, 1'b1, r);
        read_ctr("R9 busy write ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_layout();
        t_full_width();
        t_narrow_wrap();
        t_modulus_reject();
        t_compact();
        t_decrypt();
        t_busy_write();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule